// File: doc/BRIEF.md
# Linear Congruential Random Number Peripheral

This block gives a small soft processor a source of 8-bit pseudo-random values. The values come from a fixed linear congruential recurrence: the next value is the current value times 0x11, plus 0x9D, kept modulo 256. Each run starts from the fixed seed 0xD7.

Software starts a run by writing a control byte with bit 0 set. From the next cycle on, the block emits one value per clock for 255 cycles. Each value comes with a strobe and an 8-bit index, so that a neighbouring data RAM can store the value at that index. Once the last value has gone out, a sticky completion flag appears in the status byte. The next write of any value to the control register clears that flag.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `lcg_rng_periph`

## Requirements
- R1: While reset is held, and until a run starts after reset, `rnd_wr` is 0 and `status_rd` is 0x00.
- R2: In a run, the value at index i+1 equals (0x11 * v + 0x9D) mod 256, where v is the value at index i. The multiplication is unsigned.
- R3: A control write with bit 0 = 1, seen at clock edge k, makes the outputs after edge k show `rnd_wr` = 1, `rnd_addr` = 0 and `rnd_data` = 0xD7.
- R4: `rnd_wr` stays high for exactly 255 consecutive cycles, and `rnd_addr` rises by one each cycle from 0 to 254.
- R5: After the cycle that carries index 254, `rnd_wr` falls and bit 0 of `status_rd` (the done flag) becomes 1. Bits 7 to 1 of `status_rd` always read 0.
- R6: Any control write clears the done flag on the same edge, unless that edge is the one that completes a run.
- R7: A control write with bit 0 = 0 starts no run: `rnd_wr` stays 0.
- R8: A control write with bit 0 = 1 during a run restarts the run at index 0 with value 0xD7.
- R9: Consecutive runs produce identical sequences.
- R10: With no control write, the done flag holds its value and `rnd_wr` stays 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 0 starts a run |
| status_rd | output | 8 | Status byte; bit 0 is done, the rest are 0 |
| rnd_wr | output | 1 | Value strobe, intended as a RAM write enable |
| rnd_addr | output | 8 | Index of the current value |
| rnd_data | output | 8 | Current pseudo-random value |

## Verification
A wrong multiplier, increment or seed shows in `rnd_data` on the first or second strobe of a run. A fault in the index counter or the run-length logic shows in `rnd_addr`, or as a missing or extra strobe at the 255th cycle. A done flag that is set too early or too late, or that fails to clear, shows in `status_rd` within one cycle of the completing edge or of the control write. Because every value and index of several full runs is compared, a single faulty cycle anywhere in a run is caught.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned RUN_LEN = 255;
  parameter int unsigned IDX_W   = $clog2(RUN_LEN + 1);
  parameter logic [DATA_W-1:0] MULT = 8'h11;
  parameter logic [DATA_W-1:0] INCR = 8'h9D;
  parameter logic [DATA_W-1:0] SEED = 8'hD7;
endpackage

// File: rtl/lcg_rst_sync.sv
module lcg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcg_step.sv
module lcg_step #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MULT = '0,
  parameter logic [W-1:0] INCR = '0
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam int unsigned PW = 2 * W;
  logic [PW-1:0] prod;

  always_comb begin
    prod  = PW'(cur_i) * PW'(MULT) + PW'(INCR);
    nxt_o = prod[W-1:0];
  end
endmodule

// File: rtl/lcg_run_seq.sv
module lcg_run_seq #(
  parameter int unsigned RUN_LEN = 255,
  parameter int unsigned IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             start_i,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             load_o,
  output logic             adv_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RUN_LEN - 1);

  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             finish;

  always_comb begin
    finish = run_q && (idx_q == LAST) && !start_i;
    run_d  = run_q;
    idx_d  = idx_q;
    done_d = done_q;
    load_o = 1'b0;
    adv_o  = 1'b0;
    if (wr_i) done_d = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      idx_d  = '0;
      load_o = 1'b1;
    end else if (finish) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end else if (run_q) begin
      idx_d  = idx_q + 1'b1;
      adv_o  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (start_i || run_q) idx_q <= idx_d;
    end
  end

  assign run_o  = run_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && idx_q == '0));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i) |=> (!run_q || idx_q == $past(idx_q) + 1'b1));

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && idx_q == LAST && !start_i) |=> (done_q && !run_q));

  // R6
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(run_q && idx_q == LAST && !start_i)) |=> !done_q);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_i) |=> (!run_q && $stable(done_q)));
endmodule

// File: rtl/lcg_rng_periph.sv
module lcg_rng_periph
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic [DATA_W-1:0] status_rd,
  output logic              rnd_wr,
  output logic [IDX_W-1:0]  rnd_addr,
  output logic [DATA_W-1:0] rnd_data
);
  logic              rst_s_n;
  logic              start;
  logic              run, done, load, adv;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] val_q, val_d, val_nxt;

  lcg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign start = ctrl_wr && ctrl_wdata[0];

  lcg_run_seq #(.RUN_LEN(RUN_LEN), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_i    (ctrl_wr),
    .start_i (start),
    .run_o   (run),
    .idx_o   (idx),
    .done_o  (done),
    .load_o  (load),
    .adv_o   (adv)
  );

  lcg_step #(.W(DATA_W), .MULT(MULT), .INCR(INCR)) u_step (
    .cur_i (val_q),
    .nxt_o (val_nxt)
  );

  always_comb begin
    val_d = val_q;
    if (load)     val_d = SEED;
    else if (adv) val_d = val_nxt;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)        val_q <= '0;
    else if (load || adv) val_q <= val_d;
  end

  assign status_rd = {{(DATA_W-1){1'b0}}, done};
  assign rnd_wr    = run;
  assign rnd_addr  = idx;
  assign rnd_data  = val_q;

  // R2
  recur_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rnd_wr && !start && rnd_addr != IDX_W'(RUN_LEN - 1)) |=>
      (rnd_data == DATA_W'(($past(rnd_data) * MULT) + INCR)));

  // R3
  seed_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    start |=> (rnd_data == SEED));
endmodule

// File: tb/lcg_rng_periph_test.sv
module lcg_rng_periph_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] status_rd;
  logic       rnd_wr;
  logic [7:0] rnd_addr;
  logic [7:0] rnd_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  lcg_rng_periph uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .status_rd(status_rd), .rnd_wr(rnd_wr), .rnd_addr(rnd_addr), .rnd_data(rnd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic ctrl_write(input logic [7:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
    ctrl_wdata = 8'h00;
  endtask

  // Expects the current negedge to show index 0; walks the whole run.
  task automatic check_run(input string tag);
    logic [7:0] v = 8'hD7;
    for (int i = 0; i < 255; i++) begin
      check({tag, " R4 strobe"}, rnd_wr, 1);
      check({tag, " R4 index"}, rnd_addr, i);
      if (i == 0) check({tag, " R3 seed"}, rnd_data, 8'hD7);
      else        check({tag, " R2 value"}, rnd_data, v);
      check({tag, " R5 not done"}, status_rd, 0);
      v = 8'((v * 17) + 157);
      @(negedge clk);
    end
    check({tag, " R5 strobe low"}, rnd_wr, 0);
    check({tag, " R5 done"}, status_rd, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", rnd_wr, 0);
    check("R1 reset status", status_rd, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle strobe", rnd_wr, 0);
    check("R1 idle status", status_rd, 0);

    ctrl_write(8'h00);
    repeat (3) begin
      check("R7 no start", rnd_wr, 0);
      @(negedge clk);
    end

    ctrl_write(8'h01);
    check_run("run1");

    repeat (20) begin
      check("R10 done held", status_rd, 8'h01);
      check("R10 idle strobe", rnd_wr, 0);
      @(negedge clk);
    end

    ctrl_write(8'h02);
    check("R6 done cleared", status_rd, 0);
    check("R7 even write no run", rnd_wr, 0);

    ctrl_write(8'hFF);
    check_run("R9 run2");

    ctrl_write(8'h01);
    repeat (40) @(negedge clk);
    check("R8 mid-run index", rnd_addr, 40);
    ctrl_write(8'h01);
    check_run("R8 restart");

    ctrl_write(8'h00);
    check("R6 clear by zero write", status_rd, 0);
    finish_run();
  end
endmodule